// File: doc/BRIEF.md
# Prioritised Eight-Input Interrupt Controller

This block gathers up to eight edge-triggered interrupt lines, resolves them by a fixed priority and signals the processor with a single interrupt output. The processor answers with an acknowledge pulse and the block returns a vector byte. That byte is made from a programmable base and the index of the winning input. Software reaches the block through a byte-wide register port. One select bit picks between the two register addresses.

After reset the block is idle. It stays idle until software writes a short initialization sequence. The first word starts the sequence, the second word sets the vector base, and an optional cascade word and an optional mode word follow. Once running, the port accepts mask writes, end-of-interrupt commands and a readback selector. The readback selector decides whether the request register or the in-service register appears at select 0. An automatic end-of-interrupt mode lets acknowledges leave the in-service register alone. If a request drops before its acknowledge, the block returns the lowest-priority vector and marks nothing in service.

Top module: `prio_intc`

## Requirements
- R1: After reset the block is uninitialized: int_out is low, the mask reads 0xFF at select 1, both the request and in-service registers are zero, and acknowledges are ignored.
- R2: A write at select 0 with bit 4 set starts initialization, clears the in-service register and selects request readback. The next select-1 write is the base word. If bit 1 of the first word is 0, a cascade word follows. If bit 0 of the first word is 1, a mode word follows. The block runs after the last expected word.
- R3: The base word's bits 7:3 form vector bits 7:3. An acknowledge drives vector_out with the winning input index n in bits 2:0, so the vector is base+n.
- R4: When bit 1 of the mode word is 1 (automatic end-of-interrupt), acknowledges leave the in-service register unchanged. A mode word with bit 1 at 0, or no mode word, selects explicit end-of-interrupt.
- R5: While running, a select-1 write loads the mask and a select-1 read returns it. A 1 bit blocks that input from int_out and from acknowledge.
- R6: While running, a select-0 write of 0x0B makes select-0 reads return the in-service register. A write of 0x0A makes them return the request register.
- R7: A rising edge on irq_in[n] sets request bit n. The bit clears when the line goes low or when the request is acknowledged. A line held high raises no new request.
- R8: Priority is fixed, with input 0 highest. int_out is high exactly when the block runs and some unmasked request bit has higher priority than every set in-service bit.
- R9: On an acknowledge with int_out high, the winning request bit clears and, in explicit end-of-interrupt mode, its in-service bit is set.
- R10: On an acknowledge with int_out low while running, vector_out is base+7 and the in-service register is unchanged.
- R11: A select-0 write of 0x60+n while running clears in-service bit n, whatever bits are set.
- R12: A select-0 write of 0x20 while running clears the highest-priority set in-service bit.
- R13: Before initialization completes, mask writes and command writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register address select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current reg_sel |
| irq_in | input | N_IN | Interrupt request lines |
| inta | input | 1 | Acknowledge pulse, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vector_out | output | 8 | Vector returned by the last acknowledge |

## Verification
The assertions check these properties on every cycle:
- int_out stays low before initialization, and it never rises without an unmasked request.
- A mask write lands in the mask.
- A specific end-of-interrupt clears its bit.
- Acknowledges change the in-service count correctly in both end-of-interrupt modes, and spurious acknowledges return the lowest-priority index.

Only the bench's scenarios show the rest:
- The word-skipping rules of the initialization sequence.
- Nesting of a higher-priority request over an in-service one.
- Edge-only capture of a held line.
- Readback switching.
- Which bit a non-specific end-of-interrupt picks.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_BASE,
      PS_CASC,
      PS_MODE,
      PS_RUN
   } intc_state_e;

   localparam logic [2:0] CMD_EOI_ANY  = 3'b001;
   localparam logic [2:0] CMD_EOI_SPEC = 3'b011;
endpackage

// File: rtl/intc_cfg.sv
module intc_cfg
   import intc_pkg::*;
#(
   parameter int N_IN = 8,
   parameter int IDW  = $clog2(N_IN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic            sel,
   input  logic [7:0]      wdata,
   output logic            ready,
   output logic            init_go,
   output logic            eoi_any,
   output logic            eoi_spec,
   output logic [IDW-1:0]  eoi_lvl,
   output logic [7-IDW:0]  base,
   output logic            aeoi,
   output logic            rd_isr,
   output logic [N_IN-1:0] mask
);
   intc_state_e state;
   logic        single_q;
   logic        need_mode_q;
   logic        cmd_wr;

   assign ready   = (state == PS_RUN);
   assign init_go = we && !sel && wdata[4];
   assign cmd_wr  = ready && we && !sel && !wdata[4];
   assign eoi_any  = cmd_wr && !wdata[3] && (wdata[7:5] == CMD_EOI_ANY);
   assign eoi_spec = cmd_wr && !wdata[3] && (wdata[7:5] == CMD_EOI_SPEC);
   assign eoi_lvl  = wdata[IDW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= PS_IDLE;
         single_q    <= 1'b0;
         need_mode_q <= 1'b0;
         base        <= '0;
         aeoi        <= 1'b0;
         rd_isr      <= 1'b0;
         mask        <= '1;
      end else if (init_go) begin
         state       <= PS_BASE;
         single_q    <= wdata[1];
         need_mode_q <= wdata[0];
         aeoi        <= 1'b0;
         rd_isr      <= 1'b0;
      end else if (we && sel) begin
         unique case (state)
            PS_BASE: begin
               base <= wdata[7:IDW];
               if (!single_q)       state <= PS_CASC;
               else if (need_mode_q) state <= PS_MODE;
               else                  state <= PS_RUN;
            end
            PS_CASC: state <= need_mode_q ? PS_MODE : PS_RUN;
            PS_MODE: begin
               aeoi  <= wdata[1];
               state <= PS_RUN;
            end
            PS_RUN:  mask <= wdata[N_IN-1:0];
            default: state <= state;
         endcase
      end else if (cmd_wr && wdata[3] && wdata[1]) begin
         rd_isr <= wdata[0];
      end
   end
endmodule

// File: rtl/intc_irr.sv
module intc_irr #(
   parameter int N_IN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] irq_in,
   input  logic            clr_all,
   input  logic [N_IN-1:0] take,
   output logic [N_IN-1:0] irr
);
   logic [N_IN-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         irr    <= '0;
      end else begin
         line_q <= irq_in;
         if (clr_all) irr <= '0;
         else         irr <= (irr | (irq_in & ~line_q)) & irq_in & ~take;
      end
   end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
   parameter int N_IN = 8,
   parameter int IDW  = $clog2(N_IN)
) (
   input  logic [N_IN-1:0] irr,
   input  logic [N_IN-1:0] mask,
   input  logic [N_IN-1:0] isr,
   output logic            req_ok,
   output logic [IDW-1:0]  req_idx,
   output logic            isr_ok,
   output logic [IDW-1:0]  isr_idx
);
   logic [N_IN-1:0] open_upto;
   logic [N_IN-1:0] qual;

   for (genvar i = 0; i < N_IN; i++) begin : g_open
      assign open_upto[i] = ~|isr[i:0];
   end

   assign qual = irr & ~mask & open_upto;

   always_comb begin
      req_ok  = |qual;
      isr_ok  = |isr;
      req_idx = '0;
      isr_idx = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (qual[i]) req_idx = IDW'(i);
         if (isr[i])  isr_idx = IDW'(i);
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int N_IN = 8,
   localparam int IDW = $clog2(N_IN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic            reg_sel,
   input  logic [7:0]      wdata,
   output logic [7:0]      rdata,
   input  logic [N_IN-1:0] irq_in,
   input  logic            inta,
   output logic            int_out,
   output logic [7:0]      vector_out
);
   if (!(N_IN == 2 || N_IN == 4 || N_IN == 8)) begin : g_bad_n
      $error("prio_intc: N_IN must be 2, 4 or 8");
   end

   logic            ready, init_go, eoi_any, eoi_spec, aeoi, rd_isr;
   logic [IDW-1:0]  eoi_lvl, req_idx, isr_idx;
   logic [7-IDW:0]  base;
   logic [N_IN-1:0] mask, irr, isr, take, isr_set, eoi_clr;
   logic            req_ok, isr_ok, ack_hit;

   intc_cfg #(.N_IN(N_IN), .IDW(IDW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(wdata),
      .ready(ready), .init_go(init_go), .eoi_any(eoi_any), .eoi_spec(eoi_spec),
      .eoi_lvl(eoi_lvl), .base(base), .aeoi(aeoi), .rd_isr(rd_isr), .mask(mask)
   );

   intc_irr #(.N_IN(N_IN)) u_irr (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_all(init_go),
      .take(take), .irr(irr)
   );

   intc_arb #(.N_IN(N_IN), .IDW(IDW)) u_arb (
      .irr(irr), .mask(mask), .isr(isr), .req_ok(req_ok), .req_idx(req_idx),
      .isr_ok(isr_ok), .isr_idx(isr_idx)
   );

   assign int_out = ready && req_ok;
   assign ack_hit = inta && int_out;
   assign take    = ack_hit ? (N_IN'(1) << req_idx) : '0;
   assign isr_set = aeoi ? '0 : take;

   always_comb begin
      eoi_clr = '0;
      if (eoi_spec)              eoi_clr = N_IN'(1) << eoi_lvl;
      else if (eoi_any && isr_ok) eoi_clr = N_IN'(1) << isr_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr        <= '0;
         vector_out <= '0;
      end else begin
         if (init_go) isr <= '0;
         else         isr <= (isr | isr_set) & ~eoi_clr;
         if (inta && ready)
            vector_out <= {base, ack_hit ? req_idx : IDW'(N_IN - 1)};
      end
   end

   always_comb begin
      rdata = '0;
      if (reg_sel)     rdata[N_IN-1:0] = mask;
      else if (rd_isr) rdata[N_IN-1:0] = isr;
      else             rdata[N_IN-1:0] = irr;
   end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int N_IN = 8,
   localparam int IDW = $clog2(N_IN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_we,
   input logic            reg_sel,
   input logic [7:0]      wdata,
   input logic            inta,
   input logic            int_out,
   input logic [7:0]      vector_out,
   input logic            ready,
   input logic            aeoi,
   input logic [N_IN-1:0] isr,
   input logic [N_IN-1:0] irr,
   input logic [N_IN-1:0] mask
);
   // R1
   uninit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !int_out);

   // R8
   int_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr & ~mask) != '0));

   // R5
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel && ready) |=> (mask == $past(wdata[N_IN-1:0])));

   // R10
   spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && ready && !int_out) |=> (vector_out[IDW-1:0] == IDW'(N_IN - 1)));

   // R10
   spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && ready && !int_out && !reg_we) |=> $stable(isr));

   // R4
   aeoi_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && ready && aeoi && !reg_we) |=> $stable(isr));

   // R9
   ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && int_out && !aeoi && !reg_we)
      |=> ($countones(isr) == $countones($past(isr)) + 1));

   // R11
   spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_sel && ready && wdata[7:3] == 5'b01100 && !inta)
      |=> !isr[$past(wdata[IDW-1:0])]);
endmodule

bind prio_intc prio_intc_chk #(.N_IN(N_IN)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
   .wdata(wdata), .inta(inta), .int_out(int_out), .vector_out(vector_out),
   .ready(ready), .aeoi(aeoi), .isr(isr), .irr(irr), .mask(mask)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] irq_in = '0;
   logic       inta = 1'b0;
   logic       int_out;
   logic [7:0] vector_out;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   prio_intc dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .inta(inta),
      .int_out(int_out), .vector_out(vector_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic s, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic s, output logic [7:0] d);
      @(negedge clk);
      reg_sel = s;
      #1 d = rdata;
   endtask

   task automatic ack();
      @(negedge clk);
      inta = 1'b1;
      @(negedge clk);
      inta = 1'b0;
   endtask

   task automatic line(input int n, input logic v);
      @(negedge clk);
      irq_in[n] = v;
      @(negedge clk);
   endtask

   task automatic read_isr(output logic [7:0] d);
      wr(1'b0, 8'h0B);
      rd(1'b0, d);
      wr(1'b0, 8'h0A);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 int_out at reset", {7'd0, int_out}, 8'h00);
      rd(1'b1, d); chk("R1 mask at reset", d, 8'hFF);
      rd(1'b0, d); chk("R1 request reg at reset", d, 8'h00);
      ack();       chk("R1 ack ignored", vector_out, 8'h00);
      line(3, 1'b1);
      chk("R1 no int before init", {7'd0, int_out}, 8'h00);
      wr(1'b1, 8'h00);
      rd(1'b1, d); chk("R13 mask write ignored", d, 8'hFF);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R13 readback cmd ignored", d, 8'h08);
      line(3, 1'b0);
   endtask

   task automatic t_init_basic();
      logic [7:0] d;
      wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04);
      chk("R2 not running before mode word", {7'd0, int_out}, 8'h00);
      wr(1'b1, 8'h01);
      wr(1'b1, 8'hF0);
      rd(1'b1, d); chk("R5 mask readback", d, 8'hF0);
   endtask

   task automatic t_ack_basic();
      logic [7:0] d;
      line(2, 1'b1);
      chk("R8 int_out on request", {7'd0, int_out}, 8'h01);
      rd(1'b0, d); chk("R7 request bit set", d, 8'h04);
      ack();
      chk("R3 vector base+2", vector_out, 8'h22);
      read_isr(d); chk("R9 in-service after ack", d, 8'h04);
      rd(1'b0, d); chk("R6 request readback restored", d, 8'h00);
      chk("R8 int_out low after ack", {7'd0, int_out}, 8'h00);
   endtask

   task automatic t_nesting();
      logic [7:0] d;
      line(3, 1'b1);
      chk("R8 lower priority blocked", {7'd0, int_out}, 8'h00);
      line(1, 1'b1);
      chk("R8 higher priority nests", {7'd0, int_out}, 8'h01);
      ack();
      chk("R9 vector base+1", vector_out, 8'h21);
      read_isr(d); chk("R9 two in service", d, 8'h06);
      wr(1'b0, 8'h20);
      read_isr(d); chk("R12 non-specific clears top", d, 8'h04);
      chk("R8 still blocked by in-service 2", {7'd0, int_out}, 8'h00);
      wr(1'b0, 8'h62);
      read_isr(d); chk("R11 specific EOI", d, 8'h00);
      chk("R8 pending 3 now raises", {7'd0, int_out}, 8'h01);
      ack();
      chk("R7 held line gives no new request", vector_out, 8'h23);
      wr(1'b0, 8'h63);
      read_isr(d); chk("R11 specific EOI 3", d, 8'h00);
      line(1, 1'b0); line(2, 1'b0); line(3, 1'b0);
   endtask

   task automatic t_spurious();
      logic [7:0] d;
      wr(1'b1, 8'h80);
      line(7, 1'b1);
      chk("R5 masked input quiet", {7'd0, int_out}, 8'h00);
      line(7, 1'b0);
      line(5, 1'b1);
      chk("R8 int_out on 5", {7'd0, int_out}, 8'h01);
      line(5, 1'b0);
      chk("R7 request cleared by low line", {7'd0, int_out}, 8'h00);
      ack();
      chk("R10 spurious vector", vector_out, 8'h27);
      read_isr(d); chk("R10 no in-service on spurious", d, 8'h00);
   endtask

   task automatic t_auto_eoi();
      logic [7:0] d;
      wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
      rd(1'b1, d); chk("R2 mask kept over init", d, 8'h80);
      line(0, 1'b1);
      ack();
      chk("R3 vector base 0x28", vector_out, 8'h28);
      read_isr(d); chk("R4 auto EOI leaves in-service", d, 8'h00);
      line(0, 1'b0);
   endtask

   task automatic t_short_init();
      logic [7:0] d;
      wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
      wr(1'b1, 8'h55);
      rd(1'b1, d); chk("R2 single mode skips cascade word", d, 8'h55);
      line(1, 1'b1);
      ack();
      chk("R3 vector base 0x40", vector_out, 8'h41);
      read_isr(d); chk("R4 explicit mode sets in-service", d, 8'h02);
      wr(1'b0, 8'h12); wr(1'b1, 8'h50);
      wr(1'b1, 8'hAA);
      rd(1'b1, d); chk("R2 no mode word expected", d, 8'hAA);
      read_isr(d); chk("R2 init clears in-service", d, 8'h00);
      line(1, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_init_basic();
      t_ack_basic();
      t_nesting();
      t_spurious();
      t_auto_eoi();
      t_short_init();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule